// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block merges three independent reasons for resetting a processor into a single reset with a guaranteed minimum width. The three causes are a supply-undervoltage flag from an external comparator, an active-low manual-reset button input and a one-cycle watchdog-expiry strobe. The undervoltage flag and the strobe are expected to be synchronous to the system clock. The manual input is asynchronous: it passes through a synchronizer and then a stability filter, so that short noise spikes are dropped.

After every cause has cleared, the reset stays asserted for a hold period. Software-invisible pins choose one of four periods, each set by a parameter in clock cycles. Any cause that returns during the hold restarts the period. Both polarities of reset are driven and always mirror each other. A one-cycle pulse marks each new entry into reset so that other logic can react to it. The watchdog, for example, uses it to clear its timer. A synchronous system reset puts the block in the asserted state and then runs one full hold period.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst` is high, `rst_out` is 1, `rst_out_n` is 0 and `reset_rise` is 0.
- R2: After `rst` falls, `rst_out` stays 1 and returns to 0 exactly L clock edges after the last edge that sampled `rst` high. L is the hold length currently selected.
- R3: An edge that samples `uv_flag` high leaves `rst_out` at 1. `rst_out` falls exactly L edges after the last edge that sampled `uv_flag` high.
- R4: A single-cycle `wd_expire` strobe sets `rst_out` at the edge that samples it, and `rst_out` falls exactly L edges after that edge.
- R5: A low level on `mr_n` sampled at MR_FILT consecutive edges, starting at edge E, raises `rst_out` at edge E+MR_FILT+2. Two synchronizer stages plus the filter count give this delay. Once `mr_n` is sampled high at edge H, `rst_out` falls at edge H+2+L.
- R6: A low level on `mr_n` that lasts MR_FILT-1 sampled edges or fewer never sets `rst_out`. An idle `mr_n` held high never causes a reset.
- R7: A cause that appears while the hold is running keeps `rst_out` at 1 and restarts the count. Release then comes L edges after the newest cause.
- R8: `hold_sel` selects L: code 0 gives HOLD_A, 1 gives HOLD_B, 2 gives HOLD_C and 3 gives HOLD_D cycles (defaults 16, 40, 100 and 300).
- R9: `rst_out_n` is always the exact complement of `rst_out`.
- R10: `reset_rise` is 1 for exactly the one cycle after an edge at which `rst_out` goes from 0 to 1. It is never 1 for the reset state entered through `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| uv_flag | input | 1 | Supply-undervoltage flag, high while the supply is low |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wd_expire | input | 1 | One-cycle watchdog timeout strobe |
| hold_sel | input | 2 | Hold period code (0..3) |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |
| reset_rise | output | 1 | One-cycle pulse on entry into reset |

## Verification
The undervoltage flag and the strobe reach `rst_out` at the same edge that samples them. The manual input needs MR_FILT+2 edges to set the reset and two extra edges to release it. Every release lands exactly L edges after the last cause. The bench counts clock edges, and every stimulus task turns these latencies into expected values keyed to an edge number: a value one edge before the release and a value at the release itself. A monitor compares each queued item in the low phase of the clock whose edge count matches. Items that are never reached are reported as misses.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        HOLD_SHORT = 2'd0,
        HOLD_MED   = 2'd1,
        HOLD_LONG  = 2'd2,
        HOLD_XLONG = 2'd3
    } hold_code_e;

    typedef struct packed {
        logic uv;
        logic mr;
        logic wd;
    } cause_t;

    function automatic logic [31:0] pick_hold(
        input hold_code_e code,
        input logic [31:0] len_a,
        input logic [31:0] len_b,
        input logic [31:0] len_c,
        input logic [31:0] len_d
    );
        case (code)
            HOLD_SHORT: return len_a;
            HOLD_MED:   return len_b;
            HOLD_LONG:  return len_c;
            default:    return len_d;
        endcase
    endfunction

    function automatic int unsigned max4(
        input int unsigned a, input int unsigned b,
        input int unsigned c, input int unsigned d
    );
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT        = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_n,
    output logic mr_hit
);
    localparam int unsigned CW = $clog2(FILT + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;
    logic                   level;

    // synchronizer chain, idle (high) after reset
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], mr_n};
    end

    assign level = sync_q[SYNC_STAGES-1];

    // count consecutive low samples, saturating at FILT
    always_ff @(posedge clk) begin
        if (rst || level)                low_cnt <= '0;
        else if (low_cnt != CW'(FILT))   low_cnt <= low_cnt + CW'(1);
    end

    assign mr_hit = (low_cnt == CW'(FILT));

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int unsigned HCW = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cause,
    input  logic [HCW-1:0] limit,
    output logic           active
);
    logic [HCW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst || cause) begin
            active <= 1'b1;
            hcnt   <= '0;
        end else if (active) begin
            if (hcnt == limit - HCW'(1)) begin
                active <= 1'b0;
                hcnt   <= '0;
            end else begin
                hcnt <= hcnt + HCW'(1);
            end
        end
    end

endmodule

// File: rtl/sup_rise_det.sv
module sup_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic prev;

    // prev starts high so the power-on reset state gives no pulse
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= level;
    end

    assign pulse = level & ~prev;

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
    parameter int unsigned HOLD_A      = 16,
    parameter int unsigned HOLD_B      = 40,
    parameter int unsigned HOLD_C      = 100,
    parameter int unsigned HOLD_D      = 300,
    parameter int unsigned MR_FILT     = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       uv_flag,
    input  logic       mr_n,
    input  logic       wd_expire,
    input  logic [1:0] hold_sel,
    output logic       rst_out_n,
    output logic       rst_out,
    output logic       reset_rise
);
    import sup_pkg::*;

    localparam int unsigned HOLD_MAX = max4(HOLD_A, HOLD_B, HOLD_C, HOLD_D);
    localparam int unsigned HCW      = $clog2(HOLD_MAX + 1);

    logic        mr_hit;
    cause_t      src;
    logic        any_cause;
    logic [31:0] hold_lim;
    logic        active;

    sup_mr_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT(MR_FILT)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .mr_n   (mr_n),
        .mr_hit (mr_hit)
    );

    always_comb begin
        src.uv = uv_flag;
        src.mr = mr_hit;
        src.wd = wd_expire;
    end

    assign any_cause = |src;
    assign hold_lim  = pick_hold(hold_code_e'(hold_sel),
                                 32'(HOLD_A), 32'(HOLD_B), 32'(HOLD_C), 32'(HOLD_D));

    sup_hold_timer #(.HCW(HCW)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .cause  (any_cause),
        .limit  (hold_lim[HCW-1:0]),
        .active (active)
    );

    sup_rise_det u_rise (
        .clk   (clk),
        .rst   (rst),
        .level (active),
        .pulse (reset_rise)
    );

    assign rst_out   = active;
    assign rst_out_n = ~active;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        uv_flag,
    input logic        wd_expire,
    input logic        mr_hit,
    input logic [31:0] hold_lim,
    input logic        rst_out,
    input logic        rst_out_n,
    input logic        reset_rise
);
    // cycles since the last reset cause (system reset counts as one)
    logic [31:0] quiet;

    always_ff @(posedge clk) begin
        if (rst || uv_flag || wd_expire || mr_hit) quiet <= '0;
        else if (quiet != '1)                      quiet <= quiet + 32'd1;
    end

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        rst_out_n == ~rst_out); // R9

    AST_UV_SETS_RESET: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> rst_out); // R3

    AST_WD_SETS_RESET: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> rst_out); // R4

    AST_MR_SETS_RESET: assert property (@(posedge clk) disable iff (rst)
        mr_hit |=> rst_out); // R5

    AST_RELEASE_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> (quiet == hold_lim)); // R7

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reset_rise |=> !reset_rise); // R10

    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        reset_rise |-> (rst_out && !$past(rst_out))); // R10

endmodule

bind sup_reset_gen sup_reset_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .uv_flag    (uv_flag),
    .wd_expire  (wd_expire),
    .mr_hit     (mr_hit),
    .hold_lim   (hold_lim),
    .rst_out    (rst_out),
    .rst_out_n  (rst_out_n),
    .reset_rise (reset_rise)
);

// File: tb/sup_reset_gen_test.sv
module sup_reset_gen_test;

    localparam int L0 = 16;
    localparam int L1 = 40;
    localparam int L2 = 100;
    localparam int L3 = 300;
    localparam int F  = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uv_flag = 1'b0;
    logic       mr_n = 1'b1;
    logic       wd_expire = 1'b0;
    logic [1:0] hold_sel = 2'd0;
    logic       rst_out_n, rst_out, reset_rise;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int    at;
        logic  rst_v;
        logic  rise_v;
        string req;
    } exp_t;

    exp_t sb[$];

    sup_reset_gen uut (
        .clk        (clk),
        .rst        (rst),
        .uv_flag    (uv_flag),
        .mr_n       (mr_n),
        .wd_expire  (wd_expire),
        .hold_sel   (hold_sel),
        .rst_out_n  (rst_out_n),
        .rst_out    (rst_out),
        .reset_rise (reset_rise)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare queued expectations at the matching edge count
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (e.at < cyc) begin
                bad++;
                $display("FAIL %s: expectation for edge %0d missed (now %0d), expected edge %0d",
                         e.req, e.at, cyc, e.at);
            end else if (rst_out !== e.rst_v || rst_out_n !== ~e.rst_v ||
                         reset_rise !== e.rise_v) begin
                bad++;
                $display("FAIL %s (R9 polarity): edge %0d actual rst_out=%b rst_out_n=%b rise=%b expected rst_out=%b rst_out_n=%b rise=%b",
                         e.req, cyc, rst_out, rst_out_n, reset_rise,
                         e.rst_v, ~e.rst_v, e.rise_v);
            end
        end
    end

    task automatic push(input int at, input logic r, input logic ri, input string req);
        sb.push_back('{at, r, ri, req});
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic drain();
        while (sb.size() != 0) step();
        repeat (3) step();
    endtask

    task automatic check_now(input string req, input logic r, input logic ri);
        total++;
        if (rst_out !== r || rst_out_n !== ~r || reset_rise !== ri) begin
            bad++;
            $display("FAIL %s: actual rst_out=%b rst_out_n=%b rise=%b expected rst_out=%b rst_out_n=%b rise=%b",
                     req, rst_out, rst_out_n, reset_rise, r, ~r, ri);
        end
    endtask

    initial begin
        int p, s, c, c1, c2, e0, h;

        // R1: state during system reset
        repeat (4) step();
        check_now("R1", 1'b1, 1'b0);

        // R2 power-on hold with code 0 (R8: HOLD_A), no entry pulse (R10)
        rst = 1'b0;
        p = cyc;
        push(p + 1,      1'b1, 1'b0, "R10");
        push(p + L0 - 1, 1'b1, 1'b0, "R2");
        push(p + L0,     1'b0, 1'b0, "R2");
        drain();

        // R6: idle manual input causes nothing
        for (int k = 1; k <= 8; k++) push(cyc + k, 1'b0, 1'b0, "R6");
        drain();

        // R3: undervoltage, code 1 (R8: HOLD_B)
        hold_sel = 2'd1;
        step();
        uv_flag = 1'b1;
        s = cyc + 1;
        push(s,     1'b1, 1'b1, "R3");
        push(s + 1, 1'b1, 1'b0, "R10");
        repeat (5) step();
        uv_flag = 1'b0;
        c = cyc;
        push(c + L1 - 1, 1'b1, 1'b0, "R3");
        push(c + L1,     1'b0, 1'b0, "R3");
        drain();

        // R4: watchdog strobe, code 2 (R8: HOLD_C)
        hold_sel = 2'd2;
        step();
        wd_expire = 1'b1;
        s = cyc + 1;
        push(s,     1'b1, 1'b1, "R4");
        push(s + 1, 1'b1, 1'b0, "R10");
        step();
        wd_expire = 1'b0;
        push(s + L2 - 1, 1'b1, 1'b0, "R4");
        push(s + L2,     1'b0, 1'b0, "R4");
        drain();

        // R7: second strobe during the hold restarts it
        hold_sel = 2'd0;
        step();
        wd_expire = 1'b1;
        c1 = cyc + 1;
        push(c1, 1'b1, 1'b1, "R7");
        step();
        wd_expire = 1'b0;
        repeat (9) step();
        wd_expire = 1'b1;
        c2 = cyc + 1;
        push(c2, 1'b1, 1'b0, "R7");
        step();
        wd_expire = 1'b0;
        push(c1 + L0,     1'b1, 1'b0, "R7");
        push(c2 + L0 - 1, 1'b1, 1'b0, "R7");
        push(c2 + L0,     1'b0, 1'b0, "R7");
        drain();

        // R5: low for exactly F samples is accepted
        step();
        mr_n = 1'b0;
        e0 = cyc + 1;
        push(e0 + F + 1, 1'b0, 1'b0, "R5");
        push(e0 + F + 2, 1'b1, 1'b1, "R5");
        repeat (F) step();
        mr_n = 1'b1;
        push(e0 + F + 2 + L0 - 1, 1'b1, 1'b0, "R5");
        push(e0 + F + 2 + L0,     1'b0, 1'b0, "R5");
        drain();

        // R6: low for F-1 samples is rejected
        step();
        mr_n = 1'b0;
        e0 = cyc + 1;
        for (int k = 0; k <= F + 6; k++) push(e0 + k, 1'b0, 1'b0, "R6");
        repeat (F - 1) step();
        mr_n = 1'b1;
        drain();

        // R8: code 3 (HOLD_D) with a long manual press
        hold_sel = 2'd3;
        step();
        mr_n = 1'b0;
        e0 = cyc + 1;
        push(e0 + F + 1, 1'b0, 1'b0, "R8");
        push(e0 + F + 2, 1'b1, 1'b1, "R8");
        repeat (F + 4) step();
        mr_n = 1'b1;
        h = cyc + 1;
        push(h + 2 + L3 - 1, 1'b1, 1'b0, "R8");
        push(h + 2 + L3,     1'b0, 1'b0, "R8");
        drain();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule